// File: doc/BRIEF.md
# Debug Data Transfer Scan Chain

This block is the target-side half of a debug communication channel reached through a JTAG scan chain. It holds two 32-bit mailbox registers: a host-to-core register that the debugger fills and the core drains, and a core-to-host register that the core fills and the debugger drains. Each register has a full flag. The debugger side sees a 33-bit shift path driven by the TAP capture, shift and update strobes. The core side has a read-pulse port for the host-to-core word and a write port for the core-to-host word.

On capture, the chain loads the core-to-host word together with one status bit. The meaning of that status bit depends on the execute-enable input and on the test instruction in force. With execute-enable set it reports the instruction-ready flag. With execute-enable clear it reports whether the core-to-host word is valid (INTEST) or whether a write will be accepted (EXTEST, active-low retry). Under INTEST the scanned-in word is thrown away and the capture empties the core-to-host register. Under EXTEST the scanned-in word is written into the host-to-core register at update, but only if that register was empty at capture time.

The chain reacts to the TAP strobes only while its select input is high. The reset is asynchronous and active low, and its release is synchronised internally over two clock cycles.

Top module: `dbg_xfer_chain`

## Requirements
- R1: After reset, h2c_full and c2h_full are 0, tdo is 0, and core_rd_data is 0.
- R2: A selected capture loads the chain with the status bit in position 0 and the core-to-host word in positions 32..1. Each shift moves the chain one place toward position 0, with tdi entering at position 32 and tdo always showing position 0. The status bit therefore leaves first, followed by the word least-significant bit first.
- R3: With exec_en = 1, the captured status bit equals ready_in.
- R4: With exec_en = 0 and extest_sel = 0 (INTEST), the captured status bit equals c2h_full (1 = valid data).
- R5: With exec_en = 0 and extest_sel = 1 (EXTEST), the captured status bit is the inverse of h2c_full (1 = write will be taken, 0 = retry).
- R6: Under INTEST, a selected capture clears c2h_full, and a selected update leaves the host-to-core word and h2c_full unchanged.
- R7: Under EXTEST, a selected update writes chain positions 32..1 into the host-to-core word and sets h2c_full if h2c_full was 0 at the preceding capture. Otherwise the write is dropped and the word is unchanged.
- R8: core_rd_data always shows the host-to-core word, and a core_rd pulse clears h2c_full unless an accepted scan write lands in the same cycle.
- R9: A core_wr pulse loads core_wr_data and sets c2h_full. It wins over an INTEST capture in the same cycle, which still captures the previous word.
- R10: While chain_sel = 0, the TAP strobes have no effect: tdo, both flags and the host-to-core word hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_sel | input | 1 | This chain is the selected scan chain |
| extest_sel | input | 1 | 1 = EXTEST in force, 0 = INTEST |
| exec_en | input | 1 | Execute-enable state from the status register |
| ready_in | input | 1 | Instruction-ready flag |
| tap_capture | input | 1 | TAP capture strobe |
| tap_shift | input | 1 | TAP shift strobe |
| tap_update | input | 1 | TAP update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain position 0) |
| core_rd | input | 1 | Core read pulse of the host-to-core word |
| core_rd_data | output | 32 | Host-to-core word |
| core_wr | input | 1 | Core write pulse of the core-to-host word |
| core_wr_data | input | 32 | Word written by the core |
| h2c_full | output | 1 | Host-to-core register holds data |
| c2h_full | output | 1 | Core-to-host register holds data |

## Verification
Every result is registered, so each one is due in the cycle right after the clock edge that samples its stimulus. After a capture edge, tdo shows the status bit. After each shift edge, tdo shows the next word bit. After an update or core pulse, the flags and core_rd_data have their new values. The bench drives inputs on the falling edge, steps a behavioural queue model on each rising edge, and compares every output on the following falling edge, so each result is checked exactly one edge after its cause. The scan task also checks the 33 serial bits it collects against the values the requirements predict.

// File: rtl/dxc_pkg.sv
package dxc_pkg;
  typedef enum logic {
    INSTR_INTEST = 1'b0,
    INSTR_EXTEST = 1'b1
  } dxc_instr_e;

  // status bit returned at capture
  function automatic logic status_bit(input logic exec_en,
                                      input dxc_instr_e instr,
                                      input logic ready,
                                      input logic h2c_full,
                                      input logic c2h_full);
    logic res;
    if (exec_en)                   res = ready;
    else if (instr == INSTR_EXTEST) res = ~h2c_full;
    else                           res = c2h_full;
    return res;
  endfunction
endpackage

// File: rtl/dxc_shift_path.sv
module dxc_shift_path #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              shift_en,
  input  logic              tdi,
  input  logic [DATA_W-1:0] c2h_word,
  input  logic              flag_bit,
  output logic              tdo,
  output logic [DATA_W-1:0] scan_word
);
  localparam int CHAIN_W = DATA_W + 1;

  logic [CHAIN_W-1:0] sh_q, sh_d;
  logic               sh_en;

  assign sh_en = cap_en | shift_en;

  always_comb begin
    sh_d = sh_q;
    if (cap_en)        sh_d = {c2h_word, flag_bit};
    else if (shift_en) sh_d = {tdi, sh_q[CHAIN_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign tdo       = sh_q[0];
  assign scan_word = sh_q[CHAIN_W-1:1];

  // R2: status bit is the first to leave after capture
  p_capture_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (tdo == $past(flag_bit)));

  // R2: after capture the word sits above the status bit
  p_capture_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (scan_word == $past(c2h_word)));
endmodule

// File: rtl/dxc_h2c_reg.sv
module dxc_h2c_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_wr,
  input  logic              scan_grant,
  input  logic [DATA_W-1:0] scan_word,
  input  logic              core_rd,
  output logic [DATA_W-1:0] word,
  output logic              full
);
  logic [DATA_W-1:0] word_q, word_d;
  logic              full_q, full_d;
  logic              accept;

  assign accept = scan_wr & scan_grant;

  always_comb begin
    word_d = word_q;
    full_d = full_q;
    if (accept) begin
      word_d = scan_word;
      full_d = 1'b1;
    end else if (core_rd) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (accept) word_q <= word_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  assign word = word_q;
  assign full = full_q;

  // R7: accepted scan write lands and marks full
  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_wr && scan_grant) |=> (full && word == $past(scan_word)));

  // R7: refused scan write leaves the word untouched
  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_wr && !scan_grant) |=> $stable(word));

  // R8: core read empties the register
  p_rd_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rd && !scan_wr) |=> !full);
endmodule

// File: rtl/dxc_c2h_reg.sv
module dxc_c2h_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_wr,
  input  logic [DATA_W-1:0] core_wr_data,
  input  logic              drain,
  output logic [DATA_W-1:0] word,
  output logic              full
);
  logic [DATA_W-1:0] word_q;
  logic              full_q, full_d;

  always_comb begin
    full_d = full_q;
    if (core_wr)    full_d = 1'b1;
    else if (drain) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (core_wr) word_q <= core_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  assign word = word_q;
  assign full = full_q;

  // R9: core write loads the word and sets full, also against a drain
  p_wr_loads_r9: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr |=> (full && word == $past(core_wr_data)));

  // R6: INTEST capture empties the register
  p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && !core_wr) |=> !full);
endmodule

// File: rtl/dbg_xfer_chain.sv
module dbg_xfer_chain
  import dxc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chain_sel,
  input  logic              extest_sel,
  input  logic              exec_en,
  input  logic              ready_in,
  input  logic              tap_capture,
  input  logic              tap_shift,
  input  logic              tap_update,
  input  logic              tdi,
  output logic              tdo,
  input  logic              core_rd,
  output logic [DATA_W-1:0] core_rd_data,
  input  logic              core_wr,
  input  logic [DATA_W-1:0] core_wr_data,
  output logic              h2c_full,
  output logic              c2h_full
);
  // reset: asserted asynchronously, released after SYNC_STAGES edges
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  dxc_instr_e        instr;
  logic              sel_cap, sel_shift, sel_upd;
  logic              scan_wr, drain;
  logic              flag_bit;
  logic              grant_q, grant_d;
  logic [DATA_W-1:0] c2h_word, scan_word;

  assign instr     = extest_sel ? INSTR_EXTEST : INSTR_INTEST;
  assign sel_cap   = chain_sel & tap_capture;
  assign sel_shift = chain_sel & tap_shift;
  assign sel_upd   = chain_sel & tap_update;
  assign scan_wr   = sel_upd & (instr == INSTR_EXTEST);
  assign drain     = sel_cap & (instr == INSTR_INTEST);

  assign flag_bit = status_bit(exec_en, instr, ready_in, h2c_full, c2h_full);

  // write permission is fixed at capture, matching the returned retry bit
  always_comb begin
    grant_d = grant_q;
    if (sel_cap) grant_d = ~h2c_full;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   grant_q <= 1'b0;
    else if (sel_cap) grant_q <= grant_d;
  end

  dxc_shift_path #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cap_en   (sel_cap),
    .shift_en (sel_shift),
    .tdi      (tdi),
    .c2h_word (c2h_word),
    .flag_bit (flag_bit),
    .tdo      (tdo),
    .scan_word(scan_word)
  );

  dxc_h2c_reg #(.DATA_W(DATA_W)) u_h2c (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scan_wr   (scan_wr),
    .scan_grant(grant_q),
    .scan_word (scan_word),
    .core_rd   (core_rd),
    .word      (core_rd_data),
    .full      (h2c_full)
  );

  dxc_c2h_reg #(.DATA_W(DATA_W)) u_c2h (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .core_wr     (core_wr),
    .core_wr_data(core_wr_data),
    .drain       (drain),
    .word        (c2h_word),
    .full        (c2h_full)
  );

  // R3: execute-enable returns the ready flag
  p_ready_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (chain_sel && tap_capture && exec_en) |=> (tdo == $past(ready_in)));

  // R4: INTEST without execute-enable returns the valid flag
  p_valid_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (chain_sel && tap_capture && !exec_en && !extest_sel) |=> (tdo == $past(c2h_full)));

  // R5: EXTEST without execute-enable returns the active-low retry flag
  p_nretry_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (chain_sel && tap_capture && !exec_en && extest_sel) |=> (tdo == !$past(h2c_full)));

  // R6: INTEST update never touches the host-to-core side
  p_intest_keep_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (chain_sel && tap_update && !extest_sel && !core_rd) |=> ($stable(core_rd_data) && $stable(h2c_full)));

  // R10: unselected chain ignores the TAP strobes
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!chain_sel && !core_rd && !core_wr) |=>
      ($stable(tdo) && $stable(h2c_full) && $stable(c2h_full) && $stable(core_rd_data)));

  // R2: TAP strobes never overlap
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({tap_capture, tap_shift, tap_update}));
endmodule

// File: tb/sim_dbg_xfer_chain.sv
`timescale 1ns/1ps
module sim_dbg_xfer_chain;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        chain_sel, extest_sel, exec_en, ready_in;
  logic        tap_capture, tap_shift, tap_update, tdi;
  logic        tdo;
  logic        core_rd, core_wr;
  logic [31:0] core_rd_data, core_wr_data;
  logic        h2c_full, c2h_full;

  always #2.5 clk = ~clk;

  dbg_xfer_chain u0 (
    .clk(clk), .rst_n(rst_n), .chain_sel(chain_sel), .extest_sel(extest_sel),
    .exec_en(exec_en), .ready_in(ready_in), .tap_capture(tap_capture),
    .tap_shift(tap_shift), .tap_update(tap_update), .tdi(tdi), .tdo(tdo),
    .core_rd(core_rd), .core_rd_data(core_rd_data), .core_wr(core_wr),
    .core_wr_data(core_wr_data), .h2c_full(h2c_full), .c2h_full(c2h_full)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string tag   = "R1";

  // behavioural reference model
  bit          mq[$];
  logic [31:0] m_h2c, m_c2h;
  bit          m_h2c_full, m_c2h_full, m_grant;

  task automatic model_reset();
    mq.delete();
    for (int i = 0; i < 33; i++) mq.push_back(1'b0);
    m_h2c = '0; m_c2h = '0;
    m_h2c_full = 0; m_c2h_full = 0; m_grant = 0;
  endtask

  task automatic model_step();
    bit          cap, sh, upd, flag;
    logic [31:0] w;
    cap = chain_sel && tap_capture;
    sh  = chain_sel && tap_shift;
    upd = chain_sel && tap_update;
    if (exec_en)         flag = ready_in;
    else if (extest_sel) flag = !m_h2c_full;
    else                 flag = m_c2h_full;
    for (int i = 0; i < 32; i++) w[i] = mq[i+1];
    if (upd && extest_sel && m_grant) begin
      m_h2c = w; m_h2c_full = 1;
    end else if (core_rd) m_h2c_full = 0;
    if (cap) begin
      mq.delete();
      mq.push_back(flag);
      for (int i = 0; i < 32; i++) mq.push_back(m_c2h[i]);
      m_grant = !m_h2c_full_prev_hack(upd, extest_sel);
    end else if (sh) begin
      void'(mq.pop_front());
      mq.push_back(tdi);
    end
    if (core_wr) begin
      m_c2h = core_wr_data; m_c2h_full = 1;
    end else if (cap && !extest_sel) m_c2h_full = 0;
  endtask

  // capture and update never share a cycle, so h2c_full was unchanged by an
  // update in this step; a core read this step must not alter the grant
  bit pre_h2c_full;
  function automatic bit m_h2c_full_prev_hack(bit upd, logic ext);
    return (upd && ext) ? m_h2c_full : pre_h2c_full;
  endfunction

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    pre_h2c_full = m_h2c_full;
    if (!rst_n) model_reset(); else model_step();
    @(negedge clk);
    chk({tag, " tdo"},          {31'b0, tdo},      {31'b0, mq[0]});
    chk({tag, " h2c_full"},     {31'b0, h2c_full}, {31'b0, m_h2c_full});
    chk({tag, " c2h_full"},     {31'b0, c2h_full}, {31'b0, m_c2h_full});
    chk({tag, " core_rd_data"}, core_rd_data,      m_h2c);
  endtask

  task automatic idle();
    tap_capture = 0; tap_shift = 0; tap_update = 0;
    core_rd = 0; core_wr = 0; tdi = 0;
  endtask

  // full scan: capture (optionally with a core write), 33 shifts, update
  task automatic scan(input logic [31:0] din, input bit wr_at_cap,
                      input logic [31:0] wr_val,
                      output bit flag, output logic [31:0] dout);
    chain_sel = 1; tap_capture = 1;
    if (wr_at_cap) begin core_wr = 1; core_wr_data = wr_val; end
    step(); idle();
    flag = tdo;
    for (int i = 0; i < 33; i++) begin
      tap_shift = 1;
      tdi = (i == 0) ? 1'b0 : din[i-1];
      step();
      if (i < 32) dout[i] = tdo;
    end
    idle(); tap_update = 1; step(); idle(); step();
  endtask

  bit          fl;
  logic [31:0] dw;

  initial begin
    rst_n = 0; chain_sel = 0; extest_sel = 0; exec_en = 0; ready_in = 0;
    core_wr_data = '0; idle(); model_reset();
    repeat (3) step();
    tag = "R1";
    chk("R1 reset tdo",   {31'b0, tdo}, 32'd0);
    chk("R1 reset flags", {30'b0, h2c_full, c2h_full}, 32'd0);
    chk("R1 reset data",  core_rd_data, 32'd0);
    rst_n = 1;
    repeat (4) step();

    tag = "R9";
    core_wr = 1; core_wr_data = 32'hA5A5_1234; step(); idle();
    chk("R9 core write sets c2h_full", {31'b0, c2h_full}, 32'd1);

    tag = "R4";
    extest_sel = 0;
    scan(32'hDEAD_BEEF, 0, 0, fl, dw);
    chk("R4 valid flag set", {31'b0, fl}, 32'd1);
    chk("R2 scanned-out word", dw, 32'hA5A5_1234);
    chk("R6 capture drained c2h_full", {31'b0, c2h_full}, 32'd0);
    chk("R6 INTEST update discarded", core_rd_data, 32'd0);
    chk("R6 INTEST h2c_full untouched", {31'b0, h2c_full}, 32'd0);
    scan(32'h0, 0, 0, fl, dw);
    chk("R4 valid flag clear", {31'b0, fl}, 32'd0);

    tag = "R5";
    extest_sel = 1;
    scan(32'h1357_9BDF, 0, 0, fl, dw);
    chk("R5 nRetry=1 when empty", {31'b0, fl}, 32'd1);
    tag = "R7";
    chk("R7 write accepted", core_rd_data, 32'h1357_9BDF);
    chk("R7 h2c_full set", {31'b0, h2c_full}, 32'd1);
    tag = "R5";
    scan(32'hFFFF_0000, 0, 0, fl, dw);
    chk("R5 nRetry=0 when full", {31'b0, fl}, 32'd0);
    chk("R7 write dropped", core_rd_data, 32'h1357_9BDF);

    tag = "R8";
    core_rd = 1; step(); idle();
    chk("R8 core read clears h2c_full", {31'b0, h2c_full}, 32'd0);
    chk("R8 data still visible", core_rd_data, 32'h1357_9BDF);

    tag = "R3";
    exec_en = 1; ready_in = 1; extest_sel = 0;
    scan(32'h0, 0, 0, fl, dw);
    chk("R3 ready=1 returned", {31'b0, fl}, 32'd1);
    ready_in = 0; extest_sel = 1;
    scan(32'h0F0F_55AA, 0, 0, fl, dw);
    chk("R3 ready=0 returned", {31'b0, fl}, 32'd0);
    chk("R7 accepted under exec_en", core_rd_data, 32'h0F0F_55AA);
    core_rd = 1; step(); idle();
    exec_en = 0;

    tag = "R9";
    extest_sel = 0;
    core_wr = 1; core_wr_data = 32'h1111_2222; step(); idle();
    scan(32'h0, 1, 32'h3333_4444, fl, dw);
    chk("R9 capture got older word", dw, 32'h1111_2222);
    chk("R9 write beats drain", {31'b0, c2h_full}, 32'd1);
    scan(32'h0, 0, 0, fl, dw);
    chk("R9 new word scanned next", dw, 32'h3333_4444);

    tag = "R10";
    core_wr = 1; core_wr_data = 32'h8000_0001; step(); idle();
    chain_sel = 0; extest_sel = 1;
    tap_capture = 1; step(); idle();
    chk("R10 capture ignored", {31'b0, c2h_full}, 32'd1);
    for (int i = 0; i < 5; i++) begin tap_shift = 1; tdi = 1; step(); end
    idle(); tap_update = 1; step(); idle(); step();
    chk("R10 update ignored", core_rd_data, 32'h0F0F_55AA);
    chk("R10 h2c_full held", {31'b0, h2c_full}, 32'd0);

    tag = "R2";
    chain_sel = 1; extest_sel = 0;
    scan(32'h0, 0, 0, fl, dw);
    chk("R2 LSB-first word", dw, 32'h8000_0001);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule